// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a memory access may go ahead once address translation has produced the directory-level and table-level entries for the page. It reads the present, writable, user-accessible and execute-disable flags of each level. It also reads the kind of access (data read, data write or instruction fetch), the privilege of the requester (user or supervisor), a supervisor write-protect enable and an execute-disable enable. From these it gives one registered verdict.

The flags of all levels are merged so that the most restrictive one wins. A level that is read-only, supervisor-only or marked no-execute applies that restriction to the whole page. A not-present entry at any level faults whatever the access. When a check faults, the block returns an error code that tells a missing page apart from a protection violation and records the kind of access and the privilege. The result appears one clock after the request. The page walk, translation caching and exception delivery sit in the surrounding logic.

Top module: `pg_perm_check`

## Requirements
- R1: A request sampled with `chk_valid_i` high gives `res_valid_o` high on the next clock edge, with its verdict on the same cycle. In every cycle without a result, and after reset, `res_valid_o`, `allow_o`, `fault_o` and `err_code_o` are all zero.
- R2: In every cycle with `res_valid_o` high, exactly one of `allow_o` and `fault_o` is high.
- R3: If any level has its present bit at 0, the access faults for every access kind and privilege, and `err_code_o[0]` is 0.
- R4: A user access (`priv_user_i`=1) faults if any level has its user bit at 0. This holds for reads, writes and fetches.
- R5: User reads are allowed on pages whose writable bits are 0 or 1. A user write is allowed only when every level's writable bit is 1.
- R6: A supervisor read or write to a present page is allowed whatever the writable and user bits are, provided `wp_en_i` is 0.
- R7: With `wp_en_i`=1, a supervisor write faults if any level's writable bit is 0. Supervisor reads of such a page are still allowed.
- R8: An instruction fetch faults when `nx_en_i`=1 and any level's no-execute bit is 1. With `nx_en_i`=0 the no-execute bits are ignored. Data reads and writes never look at them.
- R9: A fault's error code has the following bits. Bit 0 is 1 for a protection violation and 0 for not present. Bit 1 is 1 for a write. Bit 2 is 1 for a user access. Bit 4 is 1 for an instruction fetch. Bit 3 is always 0. When the access is allowed, the code is zero.
- R10: `acc_kind_i` encodes 2'b00 as read, 2'b01 as write and 2'b10 as instruction fetch. 2'b11 is handled exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid_i | input | 1 | A check request is present this cycle |
| lvl_present_i | input | NUM_LEVELS | Present bit per level (bit 0 = directory, bit 1 = table) |
| lvl_writable_i | input | NUM_LEVELS | Writable bit per level |
| lvl_user_i | input | NUM_LEVELS | User-accessible bit per level |
| lvl_nx_i | input | NUM_LEVELS | No-execute bit per level |
| acc_kind_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| priv_user_i | input | 1 | 1 = user privilege, 0 = supervisor |
| wp_en_i | input | 1 | Enforce writable bits on supervisor writes |
| nx_en_i | input | 1 | Enforce no-execute bits on fetches |
| res_valid_o | output | 1 | Verdict valid this cycle |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 1 | Access denied |
| err_code_o | output | 5 | Fault error code |

## Verification
The bench sets each restriction at one level only, then at the other, to catch a design that checks only one level or lets the looser level win. It covers supervisor writes to read-only pages with write-protect both off and on. A design that ignored the enable would either wrongly fault copy-on-write style kernel writes or wrongly allow them. It also sends no-execute pages through data accesses and fetches with the enable on and off. This exposes a design that applies no-execute to data or ignores the enable. Finally, it sends not-present entries combined with other violations, where a design that ranked protection above presence would set error bit 0.

// File: rtl/pg_perm_pkg.sv
// Package: shared types and constants for the page permission checker.
// Assumes: the error code layout below is decoded by the fault handler.
package pg_perm_pkg;

    typedef enum logic [1:0] {
        ACC_READ     = 2'b00,
        ACC_WRITE    = 2'b01,
        ACC_FETCH    = 2'b10,
        ACC_READ_ALT = 2'b11
    } acc_kind_e;

    localparam int ERR_W        = 5;
    localparam int ERR_BIT_PROT = 0;
    localparam int ERR_BIT_WR   = 1;
    localparam int ERR_BIT_USR  = 2;
    localparam int ERR_BIT_IF   = 4;

endpackage

// File: rtl/pg_level_merge.sv
// Module: pg_level_merge
// Folds the per-level flags into one effective set for the page, with the
// most restrictive level winning. Present, writable and user need every
// level; no-execute is set if any level sets it.
// Assumes: NUM_LEVELS >= 1; purely combinational.
module pg_level_merge #(
    parameter int NUM_LEVELS = 2
) (
    input  logic [NUM_LEVELS-1:0] present_i,
    input  logic [NUM_LEVELS-1:0] writable_i,
    input  logic [NUM_LEVELS-1:0] user_i,
    input  logic [NUM_LEVELS-1:0] nx_i,
    output logic                  all_present_o,
    output logic                  all_writable_o,
    output logic                  all_user_o,
    output logic                  any_nx_o
);

    logic [NUM_LEVELS:0] p_chain;
    logic [NUM_LEVELS:0] w_chain;
    logic [NUM_LEVELS:0] u_chain;
    logic [NUM_LEVELS:0] x_chain;

    assign p_chain[0] = 1'b1;
    assign w_chain[0] = 1'b1;
    assign u_chain[0] = 1'b1;
    assign x_chain[0] = 1'b0;

    // One merge stage per translation level.
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        assign p_chain[g+1] = p_chain[g] & present_i[g];
        assign w_chain[g+1] = w_chain[g] & writable_i[g];
        assign u_chain[g+1] = u_chain[g] & user_i[g];
        assign x_chain[g+1] = x_chain[g] | nx_i[g];
    end

    assign all_present_o  = p_chain[NUM_LEVELS];
    assign all_writable_o = w_chain[NUM_LEVELS];
    assign all_user_o     = u_chain[NUM_LEVELS];
    assign any_nx_o       = x_chain[NUM_LEVELS];

endmodule

// File: rtl/pg_rule_eval.sv
// Module: pg_rule_eval
// Applies the privilege, write-protect and no-execute rules to the merged
// page flags. Gives the fault decision and the error code.
// Assumes: inputs come from pg_level_merge; purely combinational.
module pg_rule_eval
    import pg_perm_pkg::*;
(
    input  logic             all_present_i,
    input  logic             all_writable_i,
    input  logic             all_user_i,
    input  logic             any_nx_i,
    input  acc_kind_e        kind_i,
    input  logic             priv_user_i,
    input  logic             wp_en_i,
    input  logic             nx_en_i,
    output logic             fault_o,
    output logic [ERR_W-1:0] err_o
);

    logic is_write;
    logic is_fetch;
    logic usr_viol;
    logic wr_viol;
    logic nx_viol;
    logic prot_viol;

    // Decode the access kind; the spare code behaves as a read.
    always_comb begin
        is_write = (kind_i == ACC_WRITE);
        is_fetch = (kind_i == ACC_FETCH);
    end

    // Evaluate each protection rule, then the overall verdict.
    always_comb begin
        usr_viol  = priv_user_i && !all_user_i;
        wr_viol   = is_write && !all_writable_i && (priv_user_i || wp_en_i);
        nx_viol   = is_fetch && nx_en_i && any_nx_i;
        prot_viol = usr_viol || wr_viol || nx_viol;
        fault_o   = !all_present_i || prot_viol;
    end

    // Build the error code; it is zero unless the access faults.
    always_comb begin
        err_o = '0;
        if (fault_o) begin
            err_o[ERR_BIT_PROT] = all_present_i;
            err_o[ERR_BIT_WR]   = is_write;
            err_o[ERR_BIT_USR]  = priv_user_i;
            err_o[ERR_BIT_IF]   = is_fetch;
        end
    end

endmodule

// File: rtl/pg_perm_check.sv
// Module: pg_perm_check (top)
// Gives a registered allow/fault verdict for an access once translation
// has finished. The result appears one cycle after chk_valid_i.
// Assumes: bit 0 of each level vector is the directory, bit 1 the table;
// synchronous active-low reset.
module pg_perm_check
    import pg_perm_pkg::*;
#(
    parameter int NUM_LEVELS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chk_valid_i,
    input  logic [NUM_LEVELS-1:0] lvl_present_i,
    input  logic [NUM_LEVELS-1:0] lvl_writable_i,
    input  logic [NUM_LEVELS-1:0] lvl_user_i,
    input  logic [NUM_LEVELS-1:0] lvl_nx_i,
    input  logic [1:0]            acc_kind_i,
    input  logic                  priv_user_i,
    input  logic                  wp_en_i,
    input  logic                  nx_en_i,
    output logic                  res_valid_o,
    output logic                  allow_o,
    output logic                  fault_o,
    output logic [4:0]            err_code_o
);

    logic             m_present;
    logic             m_writable;
    logic             m_user;
    logic             m_nx;
    logic             c_fault;
    logic [ERR_W-1:0] c_err;
    acc_kind_e        kind;

    assign kind = acc_kind_e'(acc_kind_i);

    pg_level_merge #(.NUM_LEVELS(NUM_LEVELS)) u_merge (
        .present_i      (lvl_present_i),
        .writable_i     (lvl_writable_i),
        .user_i         (lvl_user_i),
        .nx_i           (lvl_nx_i),
        .all_present_o  (m_present),
        .all_writable_o (m_writable),
        .all_user_o     (m_user),
        .any_nx_o       (m_nx)
    );

    pg_rule_eval u_rules (
        .all_present_i  (m_present),
        .all_writable_i (m_writable),
        .all_user_i     (m_user),
        .any_nx_i       (m_nx),
        .kind_i         (kind),
        .priv_user_i    (priv_user_i),
        .wp_en_i        (wp_en_i),
        .nx_en_i        (nx_en_i),
        .fault_o        (c_fault),
        .err_o          (c_err)
    );

    // Register the verdict; outputs are quiet when no check is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            allow_o     <= 1'b0;
            fault_o     <= 1'b0;
            err_code_o  <= '0;
        end else begin
            res_valid_o <= chk_valid_i;
            allow_o     <= chk_valid_i && !c_fault;
            fault_o     <= chk_valid_i && c_fault;
            err_code_o  <= chk_valid_i ? c_err : '0;
        end
    end

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (allow_o ^ fault_o)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> (!allow_o && !fault_o && err_code_o == '0)); // R1

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |=> res_valid_o); // R1

    AST_NOT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !(&$past(lvl_present_i))) |-> (fault_o && !err_code_o[0])); // R3

    AST_USER_SUPER_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && $past(priv_user_i) && !(&$past(lvl_user_i))) |-> fault_o); // R4

    AST_SUPER_NO_WP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && (&$past(lvl_present_i)) && !$past(priv_user_i) && !$past(wp_en_i)
         && $past(acc_kind_i) != 2'b10) |-> allow_o); // R6

    AST_ALLOW_CLEAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        allow_o |-> (err_code_o == '0)); // R9

    AST_NX_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && (&$past(lvl_present_i)) && !$past(priv_user_i)
         && $past(acc_kind_i) == 2'b00) |-> allow_o); // R8

endmodule

// File: tb/pg_perm_check_tb.sv
// Bench for pg_perm_check: table-driven vectors, then directed reset,
// idle and latency checks.
module pg_perm_check_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 21;

    typedef struct packed {
        logic [1:0] pres;
        logic [1:0] wr;
        logic [1:0] us;
        logic [1:0] nx;
        logic [1:0] kind;
        logic       user;
        logic       wp;
        logic       nxen;
        logic       allow;
        logic [4:0] err;
        logic [3:0] req;
    } vec_t;

    // Kind: 00 read, 01 write, 10 fetch, 11 read-alias.
    localparam vec_t VECS [NVEC] = '{
        '{2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00000, 4'd5},  // R5 user read rw
        '{2'b11, 2'b11, 2'b11, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00000, 4'd5},  // R5 user write rw
        '{2'b11, 2'b10, 2'b11, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00111, 4'd5},  // R5 dir read-only
        '{2'b11, 2'b01, 2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00000, 4'd5},  // R5 read ro ok
        '{2'b11, 2'b11, 2'b01, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00101, 4'd4},  // R4 table super
        '{2'b11, 2'b11, 2'b10, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 5'b10101, 4'd4},  // R4 fetch super
        '{2'b11, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00000, 4'd6},  // R6 sup wr no wp
        '{2'b11, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00011, 4'd7},  // R7 wp both ro
        '{2'b11, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00000, 4'd7},  // R7 read ok
        '{2'b11, 2'b01, 2'b11, 2'b00, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00011, 4'd7},  // R7 table ro
        '{2'b11, 2'b11, 2'b00, 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 5'b10001, 4'd8},  // R8 nx fetch
        '{2'b11, 2'b11, 2'b00, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00000, 4'd8},  // R8 nx disabled
        '{2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 5'b00000, 4'd8},  // R8 data read
        '{2'b11, 2'b11, 2'b11, 2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 5'b00000, 4'd8},  // R8 data write
        '{2'b10, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd3},  // R3 dir absent
        '{2'b01, 2'b11, 2'b11, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00110, 4'd3},  // R3 table absent
        '{2'b00, 2'b11, 2'b11, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 5'b10100, 4'd3},  // R3 both absent
        '{2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 5'b10100, 4'd3},  // R3 beats prot
        '{2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00000, 4'd10}, // R10 alias read
        '{2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 5'b00000, 4'd10}, // R10 not write
        '{2'b11, 2'b11, 2'b11, 2'b00, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 5'b00000, 4'd9}   // R9 clean fetch
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       chk_valid;
    logic [1:0] pres, wr, us, nx, kind;
    logic       user, wp, nxen;
    logic       res_valid, allow, fault;
    logic [4:0] err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_perm_check #(.NUM_LEVELS(2)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .chk_valid_i    (chk_valid),
        .lvl_present_i  (pres),
        .lvl_writable_i (wr),
        .lvl_user_i     (us),
        .lvl_nx_i       (nx),
        .acc_kind_i     (kind),
        .priv_user_i    (user),
        .wp_en_i        (wp),
        .nx_en_i        (nxen),
        .res_valid_o    (res_valid),
        .allow_o        (allow),
        .fault_o        (fault),
        .err_code_o     (err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; chk_valid = 1'b1;
        pres = 2'b11; wr = 2'b11; us = 2'b11; nx = 2'b00; kind = 2'b00;
        user = 1'b0; wp = 1'b0; nxen = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs are zero during reset even with a request presented
        check("R1 reset", {res_valid, allow, fault, err}, 8'b0);
        chk_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check("R1 idle", {res_valid, allow, fault, err}, 8'b0);

        for (int i = 0; i < NVEC; i++) begin
            pres = VECS[i].pres; wr = VECS[i].wr; us = VECS[i].us; nx = VECS[i].nx;
            kind = VECS[i].kind; user = VECS[i].user; wp = VECS[i].wp; nxen = VECS[i].nxen;
            chk_valid = 1'b1;
            @(negedge clk);
            chk_valid = 1'b0;
            check($sformatf("R%0d vec%0d", VECS[i].req, i),
                  {res_valid, allow, fault, err},
                  {1'b1, VECS[i].allow, ~VECS[i].allow, VECS[i].err});
            // R2: exactly one verdict line high
            check($sformatf("R2 vec%0d", i), {7'b0, allow ^ fault}, 8'd1);
        end

        // R1: result drops the cycle after the request goes away
        @(negedge clk);
        check("R1 drop", {res_valid, allow, fault, err}, 8'b0);

        // R1: back-to-back requests each give a result on the next cycle
        pres = 2'b11; wr = 2'b11; us = 2'b11; nx = 2'b00; user = 1'b1; wp = 1'b0; nxen = 1'b0;
        kind = 2'b00; chk_valid = 1'b1;
        @(negedge clk);
        kind = 2'b01; wr = 2'b01;
        check("R1 b2b first", {res_valid, allow, fault, err}, {3'b110, 5'b00000});
        @(negedge clk);
        chk_valid = 1'b0;
        // R5: write to table read-only page from user
        check("R5 b2b second", {res_valid, allow, fault, err}, {3'b101, 5'b00111});

        // R1: reset in the middle of a result clears outputs
        chk_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", {res_valid, allow, fault, err}, 8'b0);
        rst_n = 1'b1; chk_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule